// File: doc/BRIEF.md
# Synchronous Burst Address Latch

This block is the front end of a clocked burst read path for a flash array. It watches chip enable, the active-low address-valid strobe, write enable and the address bus on each rising clock edge. It also holds a one-bit read-mode setting. Out of reset that setting selects asynchronous operation, and no burst can start until it is cleared.

Once bursts are enabled, the block captures a start address. The host can hold the strobe low for the whole burst, or pulse it low and release it. After a fixed first-access latency, the block advances an internal word address by one on every clock. A small behavioural array turns that address into a 16-bit data word. A wait flag covers the latency cycles and a valid flag covers the data cycles. Raising chip enable ends the burst and releases the data bus.

Top module: `burst_addr_latch`

## Requirements
- R1: While `rst` is high and in the cycles after it, `dq_oe`, `rdy_wait` and `data_valid` are 0 and `dq` is 0. The mode bit resets to 1, which means asynchronous.
- R2: While the mode bit is 1, a clock edge with `ce_n`=0, `adv_n`=0 and `we_n`=1 starts no burst, and `dq_oe` stays 0.
- R3: A clock edge with `cfg_we`=1 loads `cfg_async` into the mode bit. The value 0 allows bursts to start and the value 1 blocks later starts.
- R4: A burst starts only at an edge with `ce_n`=0, `adv_n`=0 and `we_n`=1. An edge with `we_n`=0 starts nothing.
- R5: Hold style: when `adv_n` stays low after the start edge, the start address is the bus value at the start edge. Later changes on `addr` are ignored.
- R6: Pulse style: during the latency phase, at the first edge where `adv_n` is sampled high after being low, the start address is replaced by the bus value at that edge.
- R7: After the start edge and the following LAT-1 edges, `rdy_wait`=1, `dq_oe`=1 and `data_valid`=0. After edge LAT counted from the start edge, `rdy_wait`=0 and `data_valid`=1.
- R8: After edge LAT+k counted from the start edge, `word_addr` equals start+k and `dq` equals (`word_addr`*0x9E37 + 0x1234) mod 2^16.
- R9: The word address increments linearly across 4-word and 16-word boundaries, and it rolls over from all ones to zero modulo 2^AW.
- R10: An edge with `ce_n`=1 ends any burst. After that edge `dq_oe`, `rdy_wait` and `data_valid` are 0 and `dq` is 0.
- R11: A new falling of `adv_n` during an active burst (sampled high, then low) restarts the burst with the bus address and the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Write enable, active low; must be high to start a burst |
| addr | input | AW | Word address bus |
| cfg_we | input | 1 | Write strobe for the read-mode bit |
| cfg_async | input | 1 | Mode value to write: 1 asynchronous, 0 burst allowed |
| dq | output | 16 | Data word; 0 when not valid |
| dq_oe | output | 1 | Data bus drive enable; low means tri-stated |
| rdy_wait | output | 1 | High during first-access latency |
| data_valid | output | 1 | High while `dq` carries a burst word |
| word_addr | output | AW | Current internal word address |

## Verification
A wrong phase or latency count shows up one edge early or late at `rdy_wait` and `data_valid`. It is therefore seen on the first burst of any sweep. A wrong captured address or a missed deassertion reload shows up at `word_addr` and `dq` on the very first valid word. A broken increment or a broken roll-over shows up on the word after the fault. Because the data is a fixed function of the address, any address error also appears on `dq` in the same cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LATENCY = 2'd1,
        PH_STREAM  = 2'd2
    } burst_phase_t;

    typedef struct packed {
        logic start;
        logic reload;
        logic restart;
    } strobe_evt_t;

    localparam logic MODE_ASYNC_RESET = 1'b1;
    localparam logic [15:0] WORD_MUL  = 16'h9E37;
    localparam logic [15:0] WORD_ADD  = 16'h1234;

    function automatic logic [15:0] word_of(input logic [31:0] a);
        logic [31:0] p;
        p = a * {16'h0, WORD_MUL} + {16'h0, WORD_ADD};
        return p[15:0];
    endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg (
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  logic cfg_async,
    output logic burst_en
);
    import burst_pkg::*;

    logic async_q;

    always_ff @(posedge clk) begin
        if (rst)
            async_q <= MODE_ASYNC_RESET;
        else if (cfg_we)
            async_q <= cfg_async;
    end

    assign burst_en = ~async_q;
endmodule

// File: rtl/burst_strobe_track.sv
module burst_strobe_track (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic adv_n,
    input  logic we_n,
    input  logic burst_en,
    output burst_pkg::strobe_evt_t evt
);
    logic adv_q;

    always_ff @(posedge clk) begin
        if (rst || ce_n)
            adv_q <= 1'b1;
        else
            adv_q <= adv_n;
    end

    always_comb begin
        evt.start   = burst_en & ~ce_n & we_n & ~adv_n;
        evt.restart = evt.start & adv_q;
        evt.reload  = ~ce_n & ~adv_q & adv_n;
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int AW  = 16,
    parameter int LAT = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce_n,
    input  logic [AW-1:0]          addr,
    input  burst_pkg::strobe_evt_t evt,
    output burst_pkg::burst_phase_t phase,
    output logic [AW-1:0]          waddr
);
    import burst_pkg::*;

    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAT_C = CW'(LAT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            waddr <= '0;
        end else if (ce_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (evt.start) begin
                        phase <= PH_LATENCY;
                        cnt   <= CW'(1);
                        waddr <= addr;
                    end
                end
                PH_LATENCY: begin
                    if (evt.restart) begin
                        cnt   <= CW'(1);
                        waddr <= addr;
                    end else begin
                        if (evt.reload)
                            waddr <= addr;
                        if (cnt == LAT_C)
                            phase <= PH_STREAM;
                        else
                            cnt <= cnt + CW'(1);
                    end
                end
                PH_STREAM: begin
                    if (evt.restart) begin
                        phase <= PH_LATENCY;
                        cnt   <= CW'(1);
                        waddr <= addr;
                    end else begin
                        waddr <= waddr + AW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/burst_word_array.sv
module burst_word_array #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] waddr,
    input  logic          rd_en,
    output logic [15:0]   word
);
    import burst_pkg::*;

    always_comb begin
        if (rd_en)
            word = word_of(32'(waddr));
        else
            word = '0;
    end
endmodule

// File: rtl/burst_addr_latch.sv
module burst_addr_latch #(
    parameter int AW  = 16,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          cfg_we,
    input  logic          cfg_async,
    output logic [15:0]   dq,
    output logic          dq_oe,
    output logic          rdy_wait,
    output logic          data_valid,
    output logic [AW-1:0] word_addr
);
    import burst_pkg::*;

    logic           burst_en;
    strobe_evt_t    evt;
    burst_phase_t   phase;
    logic [AW-1:0]  waddr;

    burst_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_async(cfg_async),
        .burst_en(burst_en)
    );

    burst_strobe_track u_strobe (
        .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
        .burst_en(burst_en), .evt(evt)
    );

    burst_seq #(.AW(AW), .LAT(LAT)) u_seq (
        .clk(clk), .rst(rst), .ce_n(ce_n), .addr(addr), .evt(evt),
        .phase(phase), .waddr(waddr)
    );

    burst_word_array #(.AW(AW)) u_array (
        .waddr(waddr), .rd_en(data_valid), .word(dq)
    );

    assign rdy_wait   = (phase == PH_LATENCY);
    assign data_valid = (phase == PH_STREAM);
    assign dq_oe      = (phase != PH_IDLE);
    assign word_addr  = waddr;
endmodule

// File: rtl/burst_addr_latch_chk.sv
module burst_addr_latch_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ce_n,
    input logic          adv_n,
    input logic          we_n,
    input logic          burst_en,
    input logic [15:0]   dq,
    input logic          dq_oe,
    input logic          rdy_wait,
    input logic          data_valid,
    input logic [AW-1:0] word_addr
);
    import burst_pkg::*;

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!dq_oe && !rdy_wait && !data_valid));

    p_no_start_async_r2: assert property (@(posedge clk) disable iff (rst)
        (!dq_oe && !burst_en) |=> !dq_oe);

    p_no_start_write_r4: assert property (@(posedge clk) disable iff (rst)
        (!dq_oe && !we_n) |=> !dq_oe);

    p_wait_leads_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (rdy_wait && !ce_n) |=> (rdy_wait || data_valid));

    p_advance_r8: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !ce_n && adv_n) |=>
            (data_valid && word_addr == AW'($past(word_addr) + 1'b1)));

    p_word_matches_r8: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (dq == word_of(32'(word_addr))));

    p_ce_releases_r10: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (!dq_oe && !rdy_wait && !data_valid && dq == 16'h0));
endmodule

bind burst_addr_latch burst_addr_latch_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .burst_en(burst_en), .dq(dq), .dq_oe(dq_oe), .rdy_wait(rdy_wait),
    .data_valid(data_valid), .word_addr(word_addr)
);

// File: tb/burst_addr_latch_test.sv
`timescale 1ns/1ps
module burst_addr_latch_test;
    localparam int AW  = 16;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_async = 1'b1;
    logic [15:0]   dq;
    logic          dq_oe;
    logic          rdy_wait;
    logic          data_valid;
    logic [AW-1:0] word_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    burst_addr_latch #(.AW(AW), .LAT(LAT)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
        .addr(addr), .cfg_we(cfg_we), .cfg_async(cfg_async), .dq(dq),
        .dq_oe(dq_oe), .rdy_wait(rdy_wait), .data_valid(data_valid),
        .word_addr(word_addr)
    );

    function automatic logic [15:0] expect_word(input logic [15:0] a);
        logic [31:0] p;
        p = {16'h0, a} * 32'h9E37 + 32'h1234;
        return p[15:0];
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] flags();
        return {dq_oe, rdy_wait, data_valid};
    endfunction

    task automatic check_idle(input string req);
        chk(flags() == 3'b000 && dq == 16'h0, req, {13'h0, flags()}, 32'h0);
    endtask

    task automatic write_mode(input logic v);
        @(negedge clk); cfg_we = 1'b1; cfg_async = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic run_burst(input bit pulse, input logic [15:0] a0,
                             input logic [15:0] a1, input int n, input string atag);
        logic [15:0] st;
        @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; addr = a0;
        @(negedge clk);
        chk(flags() == 3'b110, "R7", {13'h0, flags()}, 32'h6);
        st = pulse ? a1 : a0;
        addr = a1;
        if (pulse) adv_n = 1'b1;
        for (int j = 1; j < LAT; j++) begin
            @(negedge clk);
            chk(flags() == 3'b110, "R7", {13'h0, flags()}, 32'h6);
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(flags() == 3'b101, "R7", {13'h0, flags()}, 32'h5);
            chk(word_addr == st + 16'(k), atag, word_addr, st + 16'(k));
            chk(dq == expect_word(st + 16'(k)), "R8", dq, expect_word(st + 16'(k)));
        end
        ce_n = 1'b1; adv_n = 1'b1;
        @(negedge clk);
        check_idle("R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] starts [6];
        starts = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h7FFD, 16'h1236};

        repeat (3) @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");

        // R2: mode bit still asynchronous after reset
        ce_n = 1'b0; adv_n = 1'b0; addr = 16'h0040;
        repeat (3) begin
            @(negedge clk);
            check_idle("R2");
        end
        ce_n = 1'b1; adv_n = 1'b1;

        // R3: enable bursts
        write_mode(1'b0);
        run_burst(1'b0, 16'h0040, 16'h0041, 2, "R3");

        // R4: write enable low blocks the start
        @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; addr = 16'h0050;
        repeat (2) begin
            @(negedge clk);
            check_idle("R4");
        end
        ce_n = 1'b1; adv_n = 1'b1; we_n = 1'b1;

        // R5 / R6: sweep both strobe styles over several starts
        foreach (starts[i]) begin
            run_burst(1'b0, starts[i], starts[i] ^ 16'h0F0F, 6, "R5");
            run_burst(1'b1, starts[i], starts[i] ^ 16'h0F0F, 6, "R6");
        end

        // R9: roll-over from all ones
        run_burst(1'b0, 16'hFFFE, 16'h0000, 5, "R9");
        run_burst(1'b1, 16'h0000, 16'hFFFD, 5, "R9");

        // R11: restart during streaming
        @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; addr = 16'h0100;
        @(negedge clk); adv_n = 1'b1;
        repeat (LAT + 1) @(negedge clk);
        chk(data_valid && word_addr == 16'h0101, "R11", word_addr, 32'h0101);
        adv_n = 1'b0; addr = 16'h0200;
        @(negedge clk);
        chk(flags() == 3'b110, "R11", {13'h0, flags()}, 32'h6);
        adv_n = 1'b1;
        for (int j = 1; j < LAT; j++) begin
            @(negedge clk);
            chk(flags() == 3'b110, "R11", {13'h0, flags()}, 32'h6);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(data_valid && word_addr == 16'h0200 + 16'(k), "R11",
                word_addr, 16'h0200 + 16'(k));
        end
        ce_n = 1'b1;
        @(negedge clk);
        check_idle("R10");

        // R3: back to asynchronous blocks new starts
        write_mode(1'b1);
        @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; addr = 16'h0300;
        repeat (3) begin
            @(negedge clk);
            check_idle("R3");
        end
        ce_n = 1'b1; adv_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule